// File: doc/BRIEF.md
# Pulse-Width Bit Encoder Transmitter

This block sends a frame of data bits as a stream of fixed-length symbols on one output wire. Each symbol starts with a high pulse and ends with a low gap, and the width of the high pulse carries the bit value. A short pulse means a zero and a long pulse means a one. All timing is counted in cycles of the system clock. At a 48 MHz clock, one tick is about 21 ns.

A client presents the whole frame on a parallel input and raises `start` for one cycle while the block is idle. The block captures the frame and sends it most significant bit first, with symbols back to back. It holds `busy` high while the frame is being sent. After the low gap of the last symbol has ended, it gives a one-cycle `done` pulse. Between frames the line rests low.

Top module: `pwb_tx`

## Requirements
- R1: After reset, `line_out`, `busy` and `done` are all low. Whenever `busy` is low, `line_out` is low.
- R2: A cycle with `start` high and `busy` low accepts the frame. In the next cycle `busy` is high and `line_out` is high, because the first symbol has begun.
- R3: Every symbol lasts exactly `SYM_TICKS` clock cycles. The next symbol starts in the cycle right after the previous one ends, so rising edges within a frame are exactly `SYM_TICKS` cycles apart.
- R4: A data bit of value 0 is sent as `ZERO_HIGH` cycles of `line_out` high, then `SYM_TICKS - ZERO_HIGH` cycles low.
- R5: A data bit of value 1 is sent as `ONE_HIGH` cycles of `line_out` high, then `SYM_TICKS - ONE_HIGH` cycles low.
- R6: Bits go out in this order: `frame_data[FRAME_BITS-1]` first, down to `frame_data[0]` last. The frame value is the one present on `frame_data` in the accepting cycle.
- R7: While `busy` is high, `start` and `frame_data` have no effect. The waveform of the frame in flight does not change.
- R8: In the cycle right after the last cycle of the last symbol, `done` is high for exactly one cycle. In that same cycle `busy` has dropped and `line_out` is low.
- R9: The default parameters give 360 bits per frame and a 60-cycle symbol, with a 17-cycle high time for a 0 and a 43-cycle high time for a 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one period is one timing tick |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to send the frame on `frame_data`; taken only while idle |
| frame_data | input | FRAME_BITS | Frame contents; the MSB is sent first |
| line_out | output | 1 | Registered serial pulse-width output |
| busy | output | 1 | High while a frame is being sent |
| done | output | 1 | One-cycle pulse after the last symbol ends |

## Verification
The bound checker watches every cycle for the following:
- `line_out` stays low while idle.
- Every high pulse has one of the two legal widths.
- Rising edges inside a frame are exactly one symbol period apart.
- Acceptance raises `busy` and the line in the next cycle.
- `done` is a single-cycle pulse that coincides with the end of `busy`.

Some behaviours only the bench scenarios can show:
- Which width goes with which bit value.
- That bits go out MSB first.
- That a `start` raised mid-frame with different data leaves the waveform unchanged.

The bench sweeps every frame value of a small configuration and checks each output cycle. It also runs one full frame at the default parameters.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic {
    PWB_IDLE = 1'b0,
    PWB_SEND = 1'b1
  } pwb_state_e;
endpackage

// File: rtl/pwb_bit_shifter.sv
// Holds the captured frame and presents the bit now being sent.
module pwb_bit_shifter #(
  parameter int FRAME_BITS = 360,
  localparam int CNT_W = $clog2(FRAME_BITS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic                  advance,
  input  logic [FRAME_BITS-1:0] frame_in,
  output logic                  cur_bit,
  output logic                  last_bit
);
  logic [FRAME_BITS-1:0] sreg;
  logic [CNT_W-1:0]      idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      idx  <= '0;
    end else if (load) begin
      sreg <= frame_in;
      idx  <= '0;
    end else if (advance) begin
      sreg <= {sreg[FRAME_BITS-2:0], 1'b0};
      idx  <= idx + 1'b1;
    end
  end

  assign cur_bit  = sreg[FRAME_BITS-1];
  assign last_bit = (idx == CNT_W'(FRAME_BITS - 1));
endmodule

// File: rtl/pwb_symbol_timer.sv
// Counts the ticks of one symbol and wraps at the symbol length.
module pwb_symbol_timer #(
  parameter int SYM_TICKS = 60,
  localparam int TICK_W = $clog2(SYM_TICKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              run,
  output logic [TICK_W-1:0] tick_nxt,
  output logic              sym_end
);
  logic [TICK_W-1:0] tick;

  assign sym_end  = (tick == TICK_W'(SYM_TICKS - 1));
  assign tick_nxt = sym_end ? '0 : tick + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)          tick <= '0;
    else if (restart) tick <= '0;
    else if (run)     tick <= tick_nxt;
  end
endmodule

// File: rtl/pwb_ctrl.sv
// Frame sequencing and the registered line, busy and done outputs.
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int SYM_TICKS = 60,
  parameter int ONE_HIGH  = 43,
  parameter int ZERO_HIGH = 17,
  localparam int TICK_W = $clog2(SYM_TICKS),
  localparam int HI_W   = TICK_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cur_bit,
  input  logic              last_bit,
  input  logic              sym_end,
  input  logic [TICK_W-1:0] tick_nxt,
  output logic              accept,
  output logic              advance,
  output logic              line_out,
  output logic              busy,
  output logic              done
);
  pwb_state_e      state, state_nxt;
  logic            line_nxt, done_nxt;
  logic [HI_W-1:0] hi_len;

  assign accept  = (state == PWB_IDLE) && start;
  assign advance = (state == PWB_SEND) && sym_end && !last_bit;
  assign hi_len  = cur_bit ? HI_W'(ONE_HIGH) : HI_W'(ZERO_HIGH);

  always_comb begin
    state_nxt = state;
    line_nxt  = 1'b0;
    done_nxt  = 1'b0;
    if (accept) begin
      state_nxt = PWB_SEND;
      line_nxt  = 1'b1;
    end else if (state == PWB_SEND) begin
      if (sym_end && last_bit) begin
        state_nxt = PWB_IDLE;
        done_nxt  = 1'b1;
      end else if (sym_end) begin
        line_nxt  = 1'b1;
      end else begin
        line_nxt  = ({1'b0, tick_nxt} < hi_len);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= PWB_IDLE;
      line_out <= 1'b0;
      done     <= 1'b0;
    end else begin
      state    <= state_nxt;
      line_out <= line_nxt;
      done     <= done_nxt;
    end
  end

  assign busy = (state == PWB_SEND);
endmodule

// File: rtl/pwb_tx.sv
// Top level: pulse-width encoded frame transmitter.
module pwb_tx #(
  parameter int FRAME_BITS = 360,
  parameter int SYM_TICKS  = 60,
  parameter int ONE_HIGH   = 43,
  parameter int ZERO_HIGH  = 17,
  localparam int TICK_W = $clog2(SYM_TICKS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] frame_data,
  output logic                  line_out,
  output logic                  busy,
  output logic                  done
);
  logic              accept, advance, cur_bit, last_bit, sym_end;
  logic [TICK_W-1:0] tick_nxt;

  pwb_bit_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk(clk), .rst(rst), .load(accept), .advance(advance),
    .frame_in(frame_data), .cur_bit(cur_bit), .last_bit(last_bit)
  );

  pwb_symbol_timer #(.SYM_TICKS(SYM_TICKS)) u_timer (
    .clk(clk), .rst(rst), .restart(accept), .run(busy),
    .tick_nxt(tick_nxt), .sym_end(sym_end)
  );

  pwb_ctrl #(.SYM_TICKS(SYM_TICKS), .ONE_HIGH(ONE_HIGH), .ZERO_HIGH(ZERO_HIGH)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .cur_bit(cur_bit), .last_bit(last_bit),
    .sym_end(sym_end), .tick_nxt(tick_nxt), .accept(accept), .advance(advance),
    .line_out(line_out), .busy(busy), .done(done)
  );
endmodule

// File: rtl/pwb_tx_chk.sv
// Protocol checker for the transmitter, attached through bind.
module pwb_tx_chk #(
  parameter int SYM_TICKS = 60,
  parameter int ONE_HIGH  = 43,
  parameter int ZERO_HIGH = 17,
  localparam int CW = $clog2(SYM_TICKS + 1) + 1
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic line_out,
  input logic busy,
  input logic done
);
  logic [CW-1:0] hcnt, pcnt;
  logic          prev_line, have_rise, rise;

  assign rise = line_out && !prev_line;

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt      <= '0;
      pcnt      <= '0;
      prev_line <= 1'b0;
      have_rise <= 1'b0;
    end else begin
      hcnt      <= line_out ? hcnt + 1'b1 : '0;
      pcnt      <= rise ? CW'(1) : pcnt + 1'b1;
      prev_line <= line_out;
      have_rise <= rise ? 1'b1 : (busy ? have_rise : 1'b0);
    end
  end

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !line_out);

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && line_out));

  // R3
  period_chk: assert property (@(posedge clk) disable iff (rst)
    (rise && have_rise) |-> (pcnt == CW'(SYM_TICKS)));

  // R4 R5
  high_width_chk: assert property (@(posedge clk) disable iff (rst)
    (!line_out && hcnt != '0) |-> (hcnt == CW'(ZERO_HIGH) || hcnt == CW'(ONE_HIGH)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done && !line_out));
endmodule

bind pwb_tx pwb_tx_chk #(
  .SYM_TICKS(SYM_TICKS), .ONE_HIGH(ONE_HIGH), .ZERO_HIGH(ZERO_HIGH)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .line_out(line_out), .busy(busy), .done(done)
);

// File: tb/pwb_tx_tb.sv
module pwb_tx_tb;
  localparam int SF = 6, SS = 8, S1 = 5, S0 = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_s = 1'b0, start_f = 1'b0;
  logic [SF-1:0]  data_s = '0;
  logic [359:0]   data_f = '0;
  logic line_s, busy_s, done_s, line_f, busy_f, done_f;
  int n_checks = 0, n_fail = 0;

  always #4 clk = ~clk;

  pwb_tx #(.FRAME_BITS(SF), .SYM_TICKS(SS), .ONE_HIGH(S1), .ZERO_HIGH(S0)) u_dut (
    .clk(clk), .rst(rst), .start(start_s), .frame_data(data_s),
    .line_out(line_s), .busy(busy_s), .done(done_s)
  );

  pwb_tx u_dut_full (
    .clk(clk), .rst(rst), .start(start_f), .frame_data(data_f),
    .line_out(line_f), .busy(busy_f), .done(done_f)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_start(input bit full, input bit v, input logic [359:0] d);
    if (full) begin start_f = v; data_f = d; end
    else      begin start_s = v; data_s = d[SF-1:0]; end
  endtask

  // Sends one frame and compares every output cycle with the arithmetic model.
  task automatic run_frame(input bit full, input logic [359:0] d, input bit poke);
    int F, S, H1, H0;
    logic ln, bz, dn;
    F  = full ? 360 : SF;
    S  = full ? 60  : SS;
    H1 = full ? 43  : S1;
    H0 = full ? 17  : S0;
    @(negedge clk);
    set_start(full, 1'b1, d);
    @(negedge clk);
    set_start(full, 1'b0, d);
    for (int c = 0; c < F * S; c++) begin
      int k, t;
      logic b, e;
      k = c / S;
      t = c % S;
      b = d[F-1-k];                     // R6: MSB leaves first
      e = (t < (b ? H1 : H0));          // R3: fixed symbol slot
      ln = full ? line_f : line_s;
      bz = full ? busy_f : busy_s;
      if (c == 0) chk(bz == 1'b1 && ln == 1'b1, "R2", {bz, ln}, 3);
      if (poke) chk(ln == e, "R7", ln, e);
      else if (b) chk(ln == e, "R5", ln, e);
      else        chk(ln == e, "R4", ln, e);
      if (full) chk(ln == e, "R9", ln, e);
      if (poke && c == S + 1) set_start(full, 1'b1, ~d);
      if (poke && c == S + 2) set_start(full, 1'b0, ~d);
      @(negedge clk);
    end
    ln = full ? line_f : line_s;
    bz = full ? busy_f : busy_s;
    dn = full ? done_f : done_s;
    chk(dn == 1'b1 && bz == 1'b0 && ln == 1'b0, "R8", {dn, bz, ln}, 4);
    @(negedge clk);
    dn = full ? done_f : done_s;
    ln = full ? line_f : line_s;
    chk(dn == 1'b0 && ln == 1'b0, "R8", {dn, ln}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(line_s == 1'b0 && busy_s == 1'b0 && done_s == 1'b0, "R1", {line_s, busy_s, done_s}, 0);
    chk(line_f == 1'b0 && busy_f == 1'b0 && done_f == 1'b0, "R1", {line_f, busy_f, done_f}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(line_s == 1'b0 && busy_s == 1'b0, "R1", {line_s, busy_s}, 0);
    for (int v = 0; v < (1 << SF); v++) begin
      run_frame(1'b0, 360'(v), 1'b0);
    end
    run_frame(1'b0, 360'(6'b100101), 1'b1);
    run_frame(1'b0, 360'(6'b011010), 1'b1);
    run_frame(1'b1, {12{30'h2AC3_F15E}}, 1'b1);
    repeat (3) @(negedge clk);
    chk(line_s == 1'b0 && busy_s == 1'b0, "R1", {line_s, busy_s}, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule